// File: doc/BRIEF.md
# Segmented Packet Buffer Allocator

The block manages the storage of one port-direction packet buffer: 128 KByte cut into 256-byte segments, which gives 512 segments with a 9-bit index. It does not hold fixed address ranges per port. Every free segment sits in one shared pool, and any of 64 logical ports may draw from that pool on demand. A client presents an allocate request tagged with a logical port. One cycle later the block answers with either a segment index or a refusal, and the refusal carries its cause. A release returns a segment to the tail of the shared pool, and after that any port may receive it.

Two limits apply. Each logical port has a programmable cap on the number of segments it may hold at one time. The whole pool also has a programmable occupancy threshold, and reaching that threshold raises a flow-control output. A programmable hysteresis band keeps the flow-control output from chattering. One instance of the block serves each port in each direction. The packet data memory and all framing logic sit outside the block.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset, all 512 segments are free, `used_cnt` is 0, and `fc_out`, `rel_err` and `rsp_valid` are 0. Successive grants from the fresh pool return indices 0, 1, 2 and so on in ascending order.
- R2: An allocate request presented at a clock edge produces its response on the next edge. That response has `rsp_valid`=1, `rsp_grant`=1 and `rsp_reason`=0 when granted, and `rsp_seg` is the head of the free list.
- R3: An allocate request from a port whose held count is greater than or equal to its cap is refused with `rsp_reason`=1 (port cap). No segment is consumed.
- R4: An allocate request when no segment is free is refused with `rsp_reason`=2 (pool empty). When a request meets both conditions, the port-cap reason 1 is reported.
- R5: A released segment is appended at the tail of the free list. Any port may receive it later, and freed segments come back out in the order they were released.
- R6: An allocate and a valid release in the same cycle are both carried out, so `used_cnt` stays the same. The segment released in that cycle is never the one granted in that cycle, even when the pool was empty.
- R7: A release naming a port whose held count is 0 is ignored: `used_cnt` and the free list do not change. It also sets the sticky `rel_err` flag, which only reset clears.
- R8: `fc_out` goes to 1 on the edge at which the allocated count becomes greater than or equal to `fc_thresh`.
- R9: Once `fc_out` is set, it clears only on the edge at which the allocated count plus `fc_hyst` becomes less than `fc_thresh`. Between those two levels it holds its value.
- R10: Each port's cap resets to 512. A pulse on `cfg_cap_we` writes `cfg_cap_val` as the cap of port `cfg_cap_port` for requests from the next cycle onward. A cap lowered below the current count refuses every further request from that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cap_we | input | 1 | Write strobe for a per-port cap |
| cfg_cap_port | input | 6 | Logical port whose cap is written |
| cfg_cap_val | input | 10 | New cap value |
| fc_thresh | input | 10 | Pool occupancy that raises flow control |
| fc_hyst | input | 10 | Band below the threshold before flow control drops |
| alloc_req | input | 1 | Allocate request |
| alloc_port | input | 6 | Logical port of the allocate request |
| rel_req | input | 1 | Release request |
| rel_port | input | 6 | Logical port giving the segment back |
| rel_seg | input | 9 | Segment index being released |
| rsp_valid | output | 1 | Allocate response present |
| rsp_grant | output | 1 | 1 = segment granted, 0 = refused |
| rsp_reason | output | 2 | 0 none, 1 port cap, 2 pool empty |
| rsp_seg | output | 9 | Granted segment index |
| used_cnt | output | 10 | Segments currently allocated |
| fc_out | output | 1 | Flow-control indication |
| rel_err | output | 1 | Sticky flag for a release from an empty port |

## Verification
The bench drains the pool completely and then requests once more. A design that confused the full and empty states at that point would hand out a stale index or overflow its count. It presents an allocate and a release together on an empty pool. A design that forwarded the released index would grant in that cycle instead of refusing. It sends releases from ports that hold nothing, including a release paired with an allocate on the same port. A design that decremented anyway would corrupt `used_cnt` and the port's cap accounting. It also drives the occupancy up and down across the threshold band. An off-by-one in either comparison would move the edges of `fc_out` by one segment, and the cycle-exact reference model would catch that.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

    localparam int DEF_POOL_BYTES = 131072;
    localparam int DEF_SEG_BYTES  = 256;
    localparam int DEF_NUM_LPORTS = 64;

    typedef enum logic [1:0] {
        RSN_NONE       = 2'd0,
        RSN_PORT_CAP   = 2'd1,
        RSN_POOL_EMPTY = 2'd2
    } refuse_rsn_t;

    // True when occupancy has dropped clear of the hysteresis band.
    function automatic logic below_band(input int used, input int thr, input int hy);
        return (used + hy) < thr;
    endfunction

    // Pointer advance with wrap for a ring of any depth.
    function automatic int ring_next(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/seg_free_fifo.sv
module seg_free_fifo import seg_alloc_pkg::*; #(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] free_cnt
);

    logic [IDX_W-1:0] ring [DEPTH];
    logic [IDX_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;

    assign head_idx = ring[rd_ptr];
    assign free_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ring[i] <= IDX_W'(i);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= CNT_W'(DEPTH);
        end else begin
            if (push) begin
                ring[wr_ptr] <= push_idx;
                wr_ptr       <= IDX_W'(ring_next(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= IDX_W'(ring_next(int'(rd_ptr), DEPTH));
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CNT_W'(DEPTH)));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/seg_port_occupancy.sv
module seg_port_occupancy import seg_alloc_pkg::*; #(
    parameter int NUM_PORTS = 64,
    parameter int CNT_W     = 10,
    parameter int RESET_CAP = 512,
    localparam int PORT_W = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [CNT_W-1:0]  cfg_cap,
    input  logic [PORT_W-1:0] qry_port,
    output logic              at_cap,
    input  logic [PORT_W-1:0] chk_port,
    output logic              holds_none,
    input  logic              inc,
    input  logic [PORT_W-1:0] inc_port,
    input  logic              dec,
    input  logic [PORT_W-1:0] dec_port
);

    logic [CNT_W-1:0] held [NUM_PORTS];
    logic [CNT_W-1:0] limit [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic             hit_inc, hit_dec;
        logic [CNT_W-1:0] held_q, limit_q;

        assign hit_inc  = inc && (inc_port == PORT_W'(p));
        assign hit_dec  = dec && (dec_port == PORT_W'(p));
        assign held[p]  = held_q;
        assign limit[p] = limit_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                held_q  <= '0;
                limit_q <= CNT_W'(RESET_CAP);
            end else begin
                if (cfg_we && cfg_port == PORT_W'(p)) begin
                    limit_q <= cfg_cap;
                end
                if (hit_inc && !hit_dec) begin
                    held_q <= held_q + 1'b1;
                end else if (hit_dec && !hit_inc) begin
                    held_q <= held_q - 1'b1;
                end
            end
        end

        // R3
        under_cap_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_inc && !hit_dec) |-> (held_q < limit_q));

        // R7
        dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
            hit_dec |-> (held_q != '0));
    end

    assign at_cap     = held[qry_port] >= limit[qry_port];
    assign holds_none = held[chk_port] == '0;

endmodule

// File: rtl/seg_flow_ctrl.sv
module seg_flow_ctrl import seg_alloc_pkg::*; #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] used_nxt,
    input  logic [CNT_W-1:0] thresh,
    input  logic [CNT_W-1:0] hyst,
    output logic             fc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc <= 1'b0;
        end else if (used_nxt >= thresh) begin
            fc <= 1'b1;
        end else if (below_band(int'(used_nxt), int'(thresh), int'(hyst))) begin
            fc <= 1'b0;
        end
    end

    // R8
    fc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fc) |-> $past(used_nxt >= thresh));

    // R9
    fc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fc) |-> $past((int'(used_nxt) + int'(hyst)) < int'(thresh)));

endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc import seg_alloc_pkg::*; #(
    parameter int POOL_BYTES = DEF_POOL_BYTES,
    parameter int SEG_BYTES  = DEF_SEG_BYTES,
    parameter int NUM_LPORTS = DEF_NUM_LPORTS,
    localparam int NUM_SEGS = POOL_BYTES / SEG_BYTES,
    localparam int SEG_W    = $clog2(NUM_SEGS),
    localparam int CNT_W    = $clog2(NUM_SEGS + 1),
    localparam int PORT_W   = $clog2(NUM_LPORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cap_we,
    input  logic [PORT_W-1:0] cfg_cap_port,
    input  logic [CNT_W-1:0]  cfg_cap_val,
    input  logic [CNT_W-1:0]  fc_thresh,
    input  logic [CNT_W-1:0]  fc_hyst,
    input  logic              alloc_req,
    input  logic [PORT_W-1:0] alloc_port,
    input  logic              rel_req,
    input  logic [PORT_W-1:0] rel_port,
    input  logic [SEG_W-1:0]  rel_seg,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [1:0]        rsp_reason,
    output logic [SEG_W-1:0]  rsp_seg,
    output logic [CNT_W-1:0]  used_cnt,
    output logic              fc_out,
    output logic              rel_err
);

    logic [SEG_W-1:0] head_idx;
    logic [CNT_W-1:0] free_cnt, used_now, used_nxt;
    logic             port_full, port_empty, pool_dry;
    logic             grant, rel_ok;
    refuse_rsn_t      why;

    seg_free_fifo #(.DEPTH(NUM_SEGS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop      (grant),
        .push     (rel_ok),
        .push_idx (rel_seg),
        .head_idx (head_idx),
        .free_cnt (free_cnt)
    );

    seg_port_occupancy #(
        .NUM_PORTS (NUM_LPORTS),
        .CNT_W     (CNT_W),
        .RESET_CAP (NUM_SEGS)
    ) u_occ (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_cap_we),
        .cfg_port   (cfg_cap_port),
        .cfg_cap    (cfg_cap_val),
        .qry_port   (alloc_port),
        .at_cap     (port_full),
        .chk_port   (rel_port),
        .holds_none (port_empty),
        .inc        (grant),
        .inc_port   (alloc_port),
        .dec        (rel_ok),
        .dec_port   (rel_port)
    );

    // Decision logic: cap check outranks pool check; a same-cycle release
    // only lands in the pool after the edge, so it cannot satisfy this grant.
    assign pool_dry = (free_cnt == '0);
    assign grant    = alloc_req && !port_full && !pool_dry;
    assign rel_ok   = rel_req && !port_empty;
    assign used_now = CNT_W'(NUM_SEGS) - free_cnt;
    assign used_nxt = used_now + CNT_W'(grant) - CNT_W'(rel_ok);

    always_comb begin
        if (port_full)      why = RSN_PORT_CAP;
        else if (pool_dry)  why = RSN_POOL_EMPTY;
        else                why = RSN_NONE;
    end

    seg_flow_ctrl #(.CNT_W(CNT_W)) u_fc (
        .clk      (clk),
        .rst      (rst),
        .used_nxt (used_nxt),
        .thresh   (fc_thresh),
        .hyst     (fc_hyst),
        .fc       (fc_out)
    );

    refuse_rsn_t rsn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsn_q     <= RSN_NONE;
            rsp_seg   <= '0;
            rel_err   <= 1'b0;
        end else begin
            rsp_valid <= alloc_req;
            rsp_grant <= grant;
            rsn_q     <= alloc_req ? why : RSN_NONE;
            rsp_seg   <= grant ? head_idx : '0;
            if (rel_req && port_empty) begin
                rel_err <= 1'b1;
            end
        end
    end

    assign rsp_reason = rsn_q;
    assign used_cnt   = used_now;

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(alloc_req));

    // R7
    rel_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rel_err) |-> rel_err);

    // R6
    used_step_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(used_cnt) <= int'($past(used_cnt)) + 1) &&
        (int'(used_cnt) + 1 >= int'($past(used_cnt))));

    // R3
    grant_reason_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_grant) |-> (rsp_reason == 2'd0));

endmodule

// File: tb/seg_pool_alloc_test.sv
module seg_pool_alloc_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG  = 512;
    localparam int NPORT = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cap_we = 1'b0;
    logic [5:0] cfg_cap_port = '0;
    logic [9:0] cfg_cap_val = '0;
    logic [9:0] fc_thresh = 10'd500;
    logic [9:0] fc_hyst = 10'd100;
    logic       alloc_req = 1'b0;
    logic [5:0] alloc_port = '0;
    logic       rel_req = 1'b0;
    logic [5:0] rel_port = '0;
    logic [8:0] rel_seg = '0;
    logic       rsp_valid, rsp_grant, fc_out, rel_err;
    logic [1:0] rsp_reason;
    logic [8:0] rsp_seg;
    logic [9:0] used_cnt;

    seg_pool_alloc uut (
        .clk(clk), .rst(rst),
        .cfg_cap_we(cfg_cap_we), .cfg_cap_port(cfg_cap_port), .cfg_cap_val(cfg_cap_val),
        .fc_thresh(fc_thresh), .fc_hyst(fc_hyst),
        .alloc_req(alloc_req), .alloc_port(alloc_port),
        .rel_req(rel_req), .rel_port(rel_port), .rel_seg(rel_seg),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason),
        .rsp_seg(rsp_seg), .used_cnt(used_cnt), .fc_out(fc_out), .rel_err(rel_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    int m_free[$];
    int m_cnt[NPORT];
    int m_cap[NPORT];
    int owner[NSEG];
    int m_thr = 500;
    int m_hy = 100;
    bit m_fc = 0;
    bit m_err = 0;
    int last_seg;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find_owned(input int p);
        for (int s = 0; s < NSEG; s++) begin
            if (owner[s] == p) return s;
        end
        return -1;
    endfunction

    function automatic int reason_of(input int cnt, input int cap, input int nfree);
        if (cnt >= cap) return 1;
        if (nfree == 0) return 2;
        return 0;
    endfunction

    task automatic step(input bit ar, input int ap, input bit rr, input int rp, input int rs);
        bit e_grant;
        int e_rsn;
        int e_seg;
        int e_used;
        bit rel_ok;
        rel_ok  = rr && (m_cnt[rp] != 0);
        e_grant = 1'b0;
        e_seg   = 0;
        e_rsn   = 0;
        if (ar) begin
            e_rsn = reason_of(m_cnt[ap], m_cap[ap], m_free.size());
            if (e_rsn == 0) begin
                e_grant = 1'b1;
                e_seg = m_free.pop_front();
            end
        end
        if (rr && !rel_ok) m_err = 1'b1;
        if (rel_ok) begin
            m_cnt[rp]--;
            m_free.push_back(rs);
            owner[rs] = -1;
        end
        if (e_grant) begin
            m_cnt[ap]++;
            owner[e_seg] = ap;
        end
        e_used = NSEG - m_free.size();
        if (e_used >= m_thr) m_fc = 1'b1;
        else if (e_used + m_hy < m_thr) m_fc = 1'b0;

        alloc_req  = ar;
        alloc_port = 6'(ap);
        rel_req    = rr;
        rel_port   = 6'(rp);
        rel_seg    = 9'(rs);
        @(posedge clk);
        #1;
        alloc_req = 1'b0;
        rel_req   = 1'b0;

        chk(rsp_valid == ar, "R2 rsp_valid", int'(rsp_valid), int'(ar));
        if (ar) begin
            if (e_rsn == 1)      chk(rsp_grant == 0 && rsp_reason == 2'd1, "R3 cap refuse", int'(rsp_reason), 1);
            else if (e_rsn == 2) chk(rsp_grant == 0 && rsp_reason == 2'd2, "R4 empty refuse", int'(rsp_reason), 2);
            else begin
                chk(rsp_grant == 1 && rsp_reason == 2'd0, "R2 grant", int'(rsp_grant), 1);
                chk(int'(rsp_seg) == e_seg, "R5 free list order", int'(rsp_seg), e_seg);
            end
        end
        chk(int'(used_cnt) == e_used, "R6 used_cnt", int'(used_cnt), e_used);
        chk(fc_out == m_fc, "R9 fc_out (R8 rise)", int'(fc_out), int'(m_fc));
        chk(rel_err == m_err, "R7 rel_err", int'(rel_err), int'(m_err));
        last_seg = e_grant ? e_seg : -1;
    endtask

    task automatic set_cap(input int p, input int v);
        cfg_cap_we   = 1'b1;
        cfg_cap_port = 6'(p);
        cfg_cap_val  = 10'(v);
        @(posedge clk);
        #1;
        cfg_cap_we = 1'b0;
        m_cap[p] = v;
    endtask

    task automatic set_fc(input int thr, input int hy);
        fc_thresh = 10'(thr);
        fc_hyst   = 10'(hy);
        m_thr = thr;
        m_hy  = hy;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int s0, s1, s2;
        int x;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSEG; i++) begin
            m_free.push_back(i);
            owner[i] = -1;
        end
        for (int p = 0; p < NPORT; p++) begin
            m_cnt[p] = 0;
            m_cap[p] = NSEG;
        end

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk(used_cnt == 0, "R1 used after reset", int'(used_cnt), 0);
        chk(fc_out == 0 && rel_err == 0, "R1 flags after reset", int'(fc_out) + int'(rel_err), 0);
        chk(rsp_valid == 0, "R1 rsp_valid after reset", int'(rsp_valid), 0);

        // R1 fresh pool hands out 0,1,2
        for (int k = 0; k < 3; k++) begin
            step(1, 0, 0, 0, 0);
            chk(last_seg == k, "R1 ascending first grants", last_seg, k);
        end

        // R10 and R3: cap of port 5 set to 2
        set_cap(5, 2);
        step(1, 5, 0, 0, 0);
        step(1, 5, 0, 0, 0);
        step(1, 5, 0, 0, 0);
        chk(rsp_reason == 2'd1, "R10 new cap applied", int'(rsp_reason), 1);

        // R7: release from port 9 which holds nothing
        step(0, 0, 1, 9, 100);
        chk(rel_err == 1, "R7 sticky set", int'(rel_err), 1);
        step(0, 0, 0, 0, 0);
        chk(rel_err == 1, "R7 sticky held", int'(rel_err), 1);
        // same-port allocate and ignored release
        step(1, 9, 1, 9, 200);

        // R6: simultaneous alloc (port 1) and release of seg 0 (port 0)
        step(1, 1, 1, 0, 0);
        chk(last_seg != 0 && last_seg >= 0, "R6 released seg not reused", last_seg, 6);

        // Exhaust the pool from port 2 (cap stays at reset value 512)
        while (m_free.size() > 0) step(1, 2, 0, 0, 0);
        chk(used_cnt == 10'd512, "R10 reset cap lets port fill pool", int'(used_cnt), 512);
        chk(fc_out == 1, "R8 fc at full pool", int'(fc_out), 1);
        step(1, 3, 0, 0, 0);
        chk(rsp_reason == 2'd2, "R4 pool empty", int'(rsp_reason), 2);
        step(1, 5, 0, 0, 0);
        chk(rsp_reason == 2'd1, "R4 cap outranks empty", int'(rsp_reason), 1);

        // R6 on empty pool: released seg not granted in same cycle
        x = find_owned(2);
        step(1, 3, 1, 2, x);
        chk(rsp_grant == 0 && rsp_reason == 2'd2, "R6 no bypass on empty pool", int'(rsp_reason), 2);
        step(1, 3, 0, 0, 0);
        chk(last_seg == x, "R6 released seg granted next", last_seg, x);

        // R5: release three and reallocate them to another port in order
        s0 = find_owned(2); step(0, 0, 1, 2, s0);
        s1 = find_owned(2); step(0, 0, 1, 2, s1);
        s2 = find_owned(2); step(0, 0, 1, 2, s2);
        step(1, 7, 0, 0, 0); chk(last_seg == s0, "R5 reuse order first", last_seg, s0);
        step(1, 7, 0, 0, 0); chk(last_seg == s1, "R5 reuse order second", last_seg, s1);
        step(1, 7, 0, 0, 0); chk(last_seg == s2, "R5 reuse order third", last_seg, s2);

        // R10: lower port 2's cap below its holdings
        x = find_owned(2); step(0, 0, 1, 2, x);
        set_cap(2, 10);
        step(1, 2, 0, 0, 0);
        chk(rsp_reason == 2'd1, "R10 lowered cap refuses", int'(rsp_reason), 1);

        // Drain everything; fc falls through the hysteresis band (R9)
        for (int s = 0; s < NSEG; s++) begin
            if (owner[s] >= 0) step(0, 0, 1, owner[s], s);
        end
        chk(used_cnt == 0 && fc_out == 0, "R9 fc cleared after drain", int'(fc_out), 0);

        // Constrained random phase
        for (int p = 0; p < 8; p++) set_cap(p, 12);
        set_fc(60, 10);
        for (int blk = 0; blk < 8; blk++) begin
            for (int it = 0; it < 400; it++) begin
                bit grow, ar, rr;
                int ap, rp, rs;
                grow = (blk % 2) == 0;
                ap = $urandom_range(0, 7);
                ar = $urandom_range(0, 99) < (grow ? 75 : 25);
                rp = $urandom_range(0, 7);
                rs = find_owned(rp);
                if (rs >= 0) rr = $urandom_range(0, 99) < (grow ? 25 : 75);
                else         rr = ($urandom_range(0, 9) == 0);
                if (rs < 0) rs = 0;
                step(ar, ap, rr, rp, rs);
            end
        end
        summary();
    end

endmodule